// File: doc/BRIEF.md
# Variable Node Update with Hard Decision and Stop Control

This block performs the variable-side half of a min-sum style iterative decoder for one variable node at a time. For each node it takes a channel soft value and then a burst of check-to-variable messages, one per cycle. It forms the a-posteriori sum and then replays the node's edges one per cycle. On each replayed edge it emits the extrinsic message for that edge, saturated back to the message width, together with the edge's check-row tag, the a-posteriori value and the hard decision for the node.

The emitted hard bits feed a stop controller. The controller holds one parity bit per check row and toggles the row's bit for every edge that carries a hard 1. At the end of each iteration, the surrounding sequencer pulses an iteration-end input. If every row then has even parity, decoding stops with a syndrome-clear flag. Otherwise the iteration count goes up, and decoding stops anyway once the count reaches the cap of 16. A block-start pulse clears the count, the flags and the row parities for a new codeword.

Soft values are signed 6-bit fixed point with 2 fractional bits. The sum is kept with guard bits (9 bits by default), which covers a channel value plus up to four messages with no overflow.

Top module: `vnu_decide_top`

## Requirements
- R1: `out_app` equals the signed channel value taken with the first beat of a burst plus the signed sum of all message beats in that burst. It is held constant on every output edge of that node.
- R2: For each edge, `out_msg` equals `out_app` minus the message that arrived on that edge, clamped to the range -32..31.
- R3: `out_hard` is 0 when `out_app` is strictly greater than zero. It is 1 when `out_app` is zero or negative.
- R4: A burst of N beats, with `msg_last` on beat N, gives exactly N consecutive `out_valid` cycles. The first of these comes two clock edges after the last beat is taken. Edges come out in arrival order, each with its own `msg_row` tag on `out_row`. `in_ready` is low from the edge after the last beat until the replay ends.
- R5: Each check row keeps the XOR of the hard bits of all output edges tagged with that row since the last iteration end or block start. Edges with hard bit 0 leave the row unchanged.
- R6: An `iter_end` pulse while not done increments `iter_count` by one. If every row parity is 0 at that pulse, `done` and `synd_ok` are both set on the next edge.
- R7: If a row parity is 1 at the `iter_end` pulse that brings `iter_count` to 16, `done` rises and `synd_ok` stays 0. Before that count, `done` stays 0.
- R8: While `done` is high, `iter_end` pulses have no effect on `done`, `synd_ok` or `iter_count`.
- R9: `blk_start` clears `done`, `synd_ok`, `iter_count` and every row parity. It takes priority over a simultaneous `iter_end`.
- R10: After reset, `out_valid`, `done`, `synd_ok` and `iter_count` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_llr | input | 6 | Channel soft value, taken with the first beat of a burst |
| msg_valid | input | 1 | Message beat present |
| msg_last | input | 1 | Marks the final beat of a node's burst |
| msg_llr | input | 6 | Check-to-variable message |
| msg_row | input | 3 | Check-row tag of this edge |
| in_ready | output | 1 | High while beats are accepted |
| out_valid | output | 1 | Output edge present |
| out_msg | output | 6 | Saturated extrinsic message for the edge |
| out_row | output | 3 | Check-row tag of the output edge |
| out_hard | output | 1 | Hard decision of the node |
| out_app | output | 9 | A-posteriori sum |
| blk_start | input | 1 | Start of a new codeword |
| iter_end | input | 1 | End of one decoding iteration |
| done | output | 1 | Decoding finished |
| synd_ok | output | 1 | Finished because all rows had even parity |
| iter_count | output | 5 | Completed iterations of the current block |

## Verification
The hardest situation to reach from the ports is the cap path. The count has to climb through fifteen failing iterations without any of them clearing the parity. Each pass of the stimulus therefore sends one node with a negative sum on a fixed row, so that row stays odd at every iteration end, and done must stay low until the sixteenth pulse. Further pulses after that show the hold behaviour. A separate pass with no nodes at all shows that the parities really clear between iterations.

// File: rtl/vnu_pkg.sv
// Package vnu_pkg
// Shared types for the variable node update block.
package vnu_pkg;

    // Phase of the gather/replay sequencer
    typedef enum logic {
        PH_GATHER = 1'b0,
        PH_REPLAY = 1'b1
    } vnu_phase_e;

endpackage : vnu_pkg

// File: rtl/vnu_accum_store.sv
// Module vnu_accum_store
// Gathers one burst of check messages for one variable node. It sums them
// onto the channel value and keeps each message and row tag. After the last
// beat it replays the stored edges, one per cycle, in arrival order.
// Assumes: a burst has at most DEG beats; SUM_W >= LLR_W + clog2(DEG+1).
module vnu_accum_store
    import vnu_pkg::*;
#(
    parameter int LLR_W = 6,
    parameter int SUM_W = 9,
    parameter int DEG   = 4,
    parameter int ROW_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [LLR_W-1:0] chan_llr,
    input  logic                    msg_valid,
    input  logic                    msg_last,
    input  logic signed [LLR_W-1:0] msg_llr,
    input  logic [ROW_W-1:0]        msg_row,
    output logic                    in_ready,
    output logic                    rep_valid,
    output logic signed [LLR_W-1:0] rep_msg,
    output logic [ROW_W-1:0]        rep_row,
    output logic signed [SUM_W-1:0] rep_app
);

    localparam int CNT_W = $clog2(DEG + 1);
    localparam int EXT_W = SUM_W - LLR_W;

    vnu_phase_e              phase;
    logic [CNT_W-1:0]        wr_cnt;
    logic [CNT_W-1:0]        rd_idx;
    logic [CNT_W-1:0]        n_edges;
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] acc_base;
    logic signed [SUM_W-1:0] msg_ext;
    logic signed [LLR_W-1:0] msg_mem [DEG];
    logic [ROW_W-1:0]        row_mem [DEG];
    logic                    take;

    assign take      = msg_valid && (phase == PH_GATHER);
    assign in_ready  = (phase == PH_GATHER);
    assign rep_valid = (phase == PH_REPLAY);
    assign rep_app   = acc;

    // Pick the running sum or the sign-extended channel value as the addend base
    always_comb begin
        msg_ext  = {{EXT_W{msg_llr[LLR_W-1]}}, msg_llr};
        acc_base = (wr_cnt == '0) ? {{EXT_W{chan_llr[LLR_W-1]}}, chan_llr} : acc;
    end

    // Sequence the gather and replay phases and keep the running sum
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_GATHER;
            wr_cnt  <= '0;
            rd_idx  <= '0;
            n_edges <= '0;
            acc     <= '0;
        end else if (phase == PH_GATHER) begin
            if (msg_valid) begin
                acc <= acc_base + msg_ext;
                if (msg_last) begin
                    phase   <= PH_REPLAY;
                    n_edges <= wr_cnt + CNT_W'(1);
                    wr_cnt  <= '0;
                    rd_idx  <= '0;
                end else begin
                    wr_cnt <= wr_cnt + CNT_W'(1);
                end
            end
        end else begin
            if (rd_idx == n_edges - CNT_W'(1)) begin
                phase  <= PH_GATHER;
                rd_idx <= '0;
            end else begin
                rd_idx <= rd_idx + CNT_W'(1);
            end
        end
    end

    // One storage slot per edge position of the node
    for (genvar s = 0; s < DEG; s++) begin : g_slot
        // Capture the message and row tag arriving in this slot's position
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                msg_mem[s] <= '0;
                row_mem[s] <= '0;
            end else if (take && (wr_cnt == CNT_W'(s))) begin
                msg_mem[s] <= msg_llr;
                row_mem[s] <= msg_row;
            end
        end
    end

    // Select the slot being replayed this cycle
    always_comb begin
        rep_msg = '0;
        rep_row = '0;
        for (int s = 0; s < DEG; s++) begin
            if (rd_idx == CNT_W'(s)) begin
                rep_msg = msg_mem[s];
                rep_row = row_mem[s];
            end
        end
    end

endmodule : vnu_accum_store

// File: rtl/vnu_extrinsic.sv
// Module vnu_extrinsic
// Forms the extrinsic message of one replayed edge: the a-posteriori sum less
// that edge's own message, clamped to the message range. It also forms the
// hard bit of the node. All outputs are registered.
// Assumes: the difference fits in SUM_W+1 bits.
module vnu_extrinsic #(
    parameter int LLR_W = 6,
    parameter int SUM_W = 9,
    parameter int ROW_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rep_valid,
    input  logic signed [LLR_W-1:0] rep_msg,
    input  logic [ROW_W-1:0]        rep_row,
    input  logic signed [SUM_W-1:0] rep_app,
    output logic                    out_valid,
    output logic signed [LLR_W-1:0] out_msg,
    output logic [ROW_W-1:0]        out_row,
    output logic                    out_hard,
    output logic signed [SUM_W-1:0] out_app
);

    localparam int DIFF_W = SUM_W + 1;
    localparam int PAD_W  = DIFF_W - LLR_W;
    localparam logic signed [DIFF_W-1:0] HI = DIFF_W'((1 << (LLR_W - 1)) - 1);
    localparam logic signed [DIFF_W-1:0] LO = ~HI;

    logic signed [DIFF_W-1:0] diff;
    logic signed [LLR_W-1:0]  clamped;
    logic                     hard_n;

    // Subtract the edge's own message and clamp into the message range
    always_comb begin
        diff = {rep_app[SUM_W-1], rep_app} - {{PAD_W{rep_msg[LLR_W-1]}}, rep_msg};
        if (diff > HI) begin
            clamped = HI[LLR_W-1:0];
        end else if (diff < LO) begin
            clamped = LO[LLR_W-1:0];
        end else begin
            clamped = diff[LLR_W-1:0];
        end
        hard_n = rep_app[SUM_W-1] || (rep_app == '0);
    end

    // Register the edge result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_msg   <= '0;
            out_row   <= '0;
            out_hard  <= 1'b0;
            out_app   <= '0;
        end else begin
            out_valid <= rep_valid;
            out_msg   <= clamped;
            out_row   <= rep_row;
            out_hard  <= hard_n;
            out_app   <= rep_app;
        end
    end

endmodule : vnu_extrinsic

// File: rtl/vnu_stop_ctrl.sv
// Module vnu_stop_ctrl
// Keeps one parity bit per check row from the emitted hard bits. At each
// iteration end it decides whether decoding is finished, either because every
// row is even or because the iteration cap is reached.
// Assumes: iter_end is not pulsed while edges are still being emitted.
module vnu_stop_ctrl #(
    parameter int NROWS    = 8,
    parameter int ROW_W    = 3,
    parameter int MAX_ITER = 16,
    parameter int ITER_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              edge_valid,
    input  logic [ROW_W-1:0]  edge_row,
    input  logic              edge_hard,
    input  logic              blk_start,
    input  logic              iter_end,
    output logic              done,
    output logic              synd_ok,
    output logic [ITER_W-1:0] iter_count
);

    logic [NROWS-1:0]  parity;
    logic [ITER_W-1:0] next_count;

    assign next_count = iter_count + ITER_W'(1);

    // One parity bit per check row
    for (genvar r = 0; r < NROWS; r++) begin : g_row
        // Toggle on a hard 1 tagged with this row; clear between iterations
        always_ff @(posedge clk) begin
            if (!rst_n || blk_start || iter_end) begin
                parity[r] <= 1'b0;
            end else if (edge_valid && edge_hard && (edge_row == ROW_W'(r))) begin
                parity[r] <= ~parity[r];
            end
        end
    end

    // Count iterations and decide when decoding stops
    always_ff @(posedge clk) begin
        if (!rst_n || blk_start) begin
            iter_count <= '0;
            done       <= 1'b0;
            synd_ok    <= 1'b0;
        end else if (iter_end && !done) begin
            iter_count <= next_count;
            if (parity == '0) begin
                done    <= 1'b1;
                synd_ok <= 1'b1;
            end else if (next_count == ITER_W'(MAX_ITER)) begin
                done <= 1'b1;
            end
        end
    end

endmodule : vnu_stop_ctrl

// File: rtl/vnu_decide_top.sv
// Module vnu_decide_top
// Variable node update with hard decision and early-stop control. It wires
// the gather/replay store, the extrinsic stage and the stop controller.
// Assumes: bursts hold at most DEG beats; SUM_W covers the channel value
// plus DEG messages.
module vnu_decide_top #(
    parameter int LLR_W    = 6,
    parameter int SUM_W    = 9,
    parameter int DEG      = 4,
    parameter int NROWS    = 8,
    parameter int MAX_ITER = 16,
    localparam int ROW_W   = $clog2(NROWS),
    localparam int ITER_W  = $clog2(MAX_ITER + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [LLR_W-1:0] chan_llr,
    input  logic                    msg_valid,
    input  logic                    msg_last,
    input  logic signed [LLR_W-1:0] msg_llr,
    input  logic [ROW_W-1:0]        msg_row,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic signed [LLR_W-1:0] out_msg,
    output logic [ROW_W-1:0]        out_row,
    output logic                    out_hard,
    output logic signed [SUM_W-1:0] out_app,
    input  logic                    blk_start,
    input  logic                    iter_end,
    output logic                    done,
    output logic                    synd_ok,
    output logic [ITER_W-1:0]       iter_count
);

    logic                    rep_valid;
    logic signed [LLR_W-1:0] rep_msg;
    logic [ROW_W-1:0]        rep_row;
    logic signed [SUM_W-1:0] rep_app;

    vnu_accum_store #(
        .LLR_W(LLR_W), .SUM_W(SUM_W), .DEG(DEG), .ROW_W(ROW_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .chan_llr  (chan_llr),
        .msg_valid (msg_valid),
        .msg_last  (msg_last),
        .msg_llr   (msg_llr),
        .msg_row   (msg_row),
        .in_ready  (in_ready),
        .rep_valid (rep_valid),
        .rep_msg   (rep_msg),
        .rep_row   (rep_row),
        .rep_app   (rep_app)
    );

    vnu_extrinsic #(
        .LLR_W(LLR_W), .SUM_W(SUM_W), .ROW_W(ROW_W)
    ) u_ext (
        .clk       (clk),
        .rst_n     (rst_n),
        .rep_valid (rep_valid),
        .rep_msg   (rep_msg),
        .rep_row   (rep_row),
        .rep_app   (rep_app),
        .out_valid (out_valid),
        .out_msg   (out_msg),
        .out_row   (out_row),
        .out_hard  (out_hard),
        .out_app   (out_app)
    );

    vnu_stop_ctrl #(
        .NROWS(NROWS), .ROW_W(ROW_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
    ) u_stop (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_valid (out_valid),
        .edge_row   (out_row),
        .edge_hard  (out_hard),
        .blk_start  (blk_start),
        .iter_end   (iter_end),
        .done       (done),
        .synd_ok    (synd_ok),
        .iter_count (iter_count)
    );

endmodule : vnu_decide_top

// File: rtl/vnu_decide_checker.sv
// Module vnu_decide_checker
// Temporal properties of the variable node block, attached by bind.
module vnu_decide_checker #(
    parameter int SUM_W    = 9,
    parameter int MAX_ITER = 16,
    parameter int ITER_W   = 5
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_hard,
    input logic signed [SUM_W-1:0] out_app,
    input logic                    blk_start,
    input logic                    iter_end,
    input logic                    done,
    input logic [ITER_W-1:0]       iter_count
);

    // R1: sum and hard bit hold across one node's consecutive edges
    assert_app_steady_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> ($stable(out_app) && $stable(out_hard)));

    // R4: leaving the gather phase is followed by an output edge
    assert_replay_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ready) |=> out_valid);

    // R6: a counted iteration end advances the count by one
    assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_end && !done && !blk_start) |=> (iter_count == ITER_W'($past(iter_count) + 1'b1)));

    // R7: reaching the cap means finished
    assert_cap_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (iter_count == ITER_W'(MAX_ITER)) |-> done);

    // R8: finished state holds until a new block
    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !blk_start) |=> (done && $stable(iter_count)));

    // R9: a new block clears the stop state
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start |=> (!done && iter_count == '0));

endmodule : vnu_decide_checker

bind vnu_decide_top vnu_decide_checker #(
    .SUM_W(SUM_W), .MAX_ITER(MAX_ITER), .ITER_W(ITER_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_hard   (out_hard),
    .out_app    (out_app),
    .blk_start  (blk_start),
    .iter_end   (iter_end),
    .done       (done),
    .iter_count (iter_count)
);

// File: tb/vnu_decide_top_tb.sv
// Directed bench for vnu_decide_top.
module vnu_decide_top_tb;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [5:0] chan_llr = '0;
    logic              msg_valid = 1'b0;
    logic              msg_last = 1'b0;
    logic signed [5:0] msg_llr = '0;
    logic [2:0]        msg_row = '0;
    logic              in_ready;
    logic              out_valid;
    logic signed [5:0] out_msg;
    logic [2:0]        out_row;
    logic              out_hard;
    logic signed [8:0] out_app;
    logic              blk_start = 1'b0;
    logic              iter_end = 1'b0;
    logic              done;
    logic              synd_ok;
    logic [4:0]        iter_count;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    vnu_decide_top u_dut (
        .clk(clk), .rst_n(rst_n), .chan_llr(chan_llr), .msg_valid(msg_valid),
        .msg_last(msg_last), .msg_llr(msg_llr), .msg_row(msg_row),
        .in_ready(in_ready), .out_valid(out_valid), .out_msg(out_msg),
        .out_row(out_row), .out_hard(out_hard), .out_app(out_app),
        .blk_start(blk_start), .iter_end(iter_end), .done(done),
        .synd_ok(synd_ok), .iter_count(iter_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clamp6(input int v);
        if (v > 31) return 31;
        if (v < -32) return -32;
        return v;
    endfunction

    // Send one node burst and check every output edge
    task automatic send_node(input int chan, input int n, input int m[4], input int r[4]);
        int app = chan;
        int hard;
        for (int k = 0; k < n; k++) app += m[k];
        hard = (app > 0) ? 0 : 1;
        while (!in_ready) @(negedge clk);
        for (int k = 0; k < n; k++) begin
            chan_llr  = 6'(chan);
            msg_valid = 1'b1;
            msg_llr   = 6'(m[k]);
            msg_row   = 3'(r[k]);
            msg_last  = (k == n - 1);
            @(negedge clk);
        end
        msg_valid = 1'b0;
        msg_last  = 1'b0;
        check(in_ready == 1'b0, "R4 in_ready low in replay", int'(in_ready), 0);
        for (int e = 0; e < n; e++) begin
            int guard = 0;
            while (!out_valid && guard < 20) begin
                @(negedge clk);
                guard++;
            end
            check(out_valid == 1'b1, "R4 edge present", int'(out_valid), 1);
            check(int'(out_app) == app, "R1 a-posteriori sum", int'(out_app), app);
            check(int'(out_msg) == clamp6(app - m[e]), "R2 extrinsic message", int'(out_msg), clamp6(app - m[e]));
            check(int'(out_hard) == hard, "R3 hard decision", int'(out_hard), hard);
            check(int'(out_row) == r[e], "R4 row order", int'(out_row), r[e]);
            @(negedge clk);
        end
        check(out_valid == 1'b0, "R4 edge count", int'(out_valid), 0);
    endtask

    task automatic pulse_iter_end();
        iter_end = 1'b1;
        @(negedge clk);
        iter_end = 1'b0;
    endtask

    task automatic pulse_start();
        blk_start = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
    endtask

    task automatic t_reset();
        check(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        check(done == 1'b0, "R10 done", int'(done), 0);
        check(synd_ok == 1'b0, "R10 synd_ok", int'(synd_ok), 0);
        check(iter_count == 0, "R10 iter_count", int'(iter_count), 0);
        check(in_ready == 1'b1, "R10 in_ready", int'(in_ready), 1);
    endtask

    task automatic t_arith();
        send_node(5, 3, '{3, -2, 7, 0}, '{1, 4, 6, 0});      // positive sum
        send_node(-10, 2, '{-4, 2, 0, 0}, '{7, 0, 0, 0});    // negative sum
        send_node(3, 1, '{-3, 0, 0, 0}, '{2, 0, 0, 0});      // R3 zero sum gives 1
        send_node(31, 3, '{31, 31, 31, 0}, '{0, 1, 2, 0});   // R2 upper clamp
        send_node(-32, 3, '{-32, -32, -32, 0}, '{3, 4, 5, 0}); // R2 lower clamp
        send_node(31, 4, '{31, 31, 31, 31}, '{0, 1, 2, 3});  // R1 full degree, guard bits
    endtask

    task automatic t_even_rows();
        pulse_start();
        send_node(-4, 2, '{-1, -2, 0, 0}, '{0, 1, 0, 0});
        send_node(-4, 2, '{-3, -1, 0, 0}, '{1, 0, 0, 0});
        send_node(10, 1, '{2, 0, 0, 0}, '{5, 0, 0, 0});     // R5 hard 0 leaves row 5 even
        pulse_iter_end();
        check(done == 1'b1, "R6 done on even rows", int'(done), 1);
        check(synd_ok == 1'b1, "R6 synd_ok on even rows", int'(synd_ok), 1);
        check(iter_count == 1, "R6 count", int'(iter_count), 1);
    endtask

    task automatic t_odd_then_clear();
        pulse_start();
        check(done == 1'b0, "R9 done cleared", int'(done), 0);
        check(iter_count == 0, "R9 count cleared", int'(iter_count), 0);
        send_node(-5, 1, '{-1, 0, 0, 0}, '{2, 0, 0, 0});
        pulse_iter_end();
        check(done == 1'b0, "R5 odd row keeps going", int'(done), 0);
        check(iter_count == 1, "R6 count after odd", int'(iter_count), 1);
        pulse_iter_end();                                     // R5 rows cleared at iteration end
        check(done == 1'b1, "R5 cleared rows stop", int'(done), 1);
        check(synd_ok == 1'b1, "R5 synd_ok after clear", int'(synd_ok), 1);
        check(iter_count == 2, "R6 count two", int'(iter_count), 2);
    endtask

    task automatic t_cap_and_hold();
        pulse_start();
        for (int it = 1; it <= 16; it++) begin
            send_node(-5, 1, '{-1, 0, 0, 0}, '{3, 0, 0, 0});
            pulse_iter_end();
            check(iter_count == it, "R7 count step", int'(iter_count), it);
            check(int'(done) == (it == 16), "R7 done at cap only", int'(done), int'(it == 16));
        end
        check(synd_ok == 1'b0, "R7 cap is not syndrome", int'(synd_ok), 0);
        pulse_iter_end();
        pulse_iter_end();
        check(iter_count == 16, "R8 count holds", int'(iter_count), 16);
        check(done == 1'b1, "R8 done holds", int'(done), 1);
        check(synd_ok == 1'b0, "R8 synd_ok holds", int'(synd_ok), 0);
        blk_start = 1'b1;                                     // R9 priority over iter_end
        iter_end  = 1'b1;
        @(negedge clk);
        blk_start = 1'b0;
        iter_end  = 1'b0;
        check(iter_count == 0, "R9 start wins count", int'(iter_count), 0);
        check(done == 1'b0, "R9 start wins done", int'(done), 0);
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                failures++;
                $display("FAIL watchdog R10 actual=%0d expected=<100000", cycles);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arith();
        t_even_rows();
        t_odd_then_clear();
        t_cap_and_hold();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule : vnu_decide_top_tb